// File: doc/BRIEF.md
# Sequential Instruction Prefetch Stream Buffer

This block sits next to an instruction cache and services its misses. When the cache misses, it reads the missing block from memory and returns it on a fill port. It then reads the next sequential block address from memory. That second block is not sent to the cache. It is held in a single-entry stream buffer. The next miss probes this buffer before memory is used. On a buffer hit the block is returned in one cycle, and a read of the block after it starts at once.

The requester raises `miss_req_i` with a block address and keeps both steady until `fill_valid_o` pulses. It then lowers the request. The memory port carries one read at a time. A request is held until `mem_ack_i` is sampled high, and the data arrives in that same cycle. The block may withdraw or redirect a request that has not been acknowledged yet. A demand miss that arrives while a prefetch is still outstanding takes the port straight away.

Top module: `seq_pf_stream_buf`

## Requirements
- R1: While `rst_ni` is low, `fill_valid_o`, `mem_req_o` and `stall_o` are 0 and the buffer is emptied. The first miss after reset always reads memory.
- R2: A miss accepted in a cycle when the buffer does not hold a valid copy of that address does three things from the next cycle on. It drives `mem_req_o`=1 with `mem_addr_o` equal to the miss address. It raises `stall_o`. It invalidates the buffer.
- R3: When the demand read's `mem_ack_i` is sampled, `fill_valid_o` is 1 in the next cycle only, `fill_data_o` carries the acknowledged data and `stall_o` returns to 0. With a memory latency of L idle cycles, the fill therefore comes L+2 cycles after acceptance.
- R4: In the cycle the demand fill is shown, `mem_req_o`=1 with `mem_addr_o` equal to the miss address plus one. The data of that read is parked in the buffer and is not put on the fill port.
- R5: A miss to the address held valid in the buffer gives `fill_valid_o` one cycle after acceptance, with the parked data. No demand read is made. In that same cycle a read of the address plus one is requested.
- R6: A buffer miss discards the parked block. A later miss to that old address goes to memory.
- R7: A prefetch that has been requested but not yet loaded counts as a buffer miss, even when its address equals the miss address. This includes a prefetch whose acknowledge comes in the accept cycle. The demand read replaces it on the port in the next cycle.
- R8: While a demand read waits, `mem_req_o` stays 1 and `mem_addr_o` stays constant until the acknowledge.
- R9: `mem_ack_i` while `mem_req_o` is 0 produces no fill and leaves the buffer contents unchanged.
- R10: Block addresses wrap modulo 2^ADDR_W. The prefetch after the all-ones address targets address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_req_i | input | 1 | Cache miss request, held until fill |
| miss_addr_i | input | ADDR_W | Missing block address |
| fill_valid_o | output | 1 | One-cycle pulse: fill data valid |
| fill_data_o | output | DATA_W | Block returned to the cache |
| stall_o | output | 1 | Demand read outstanding, fetch stalled |
| mem_req_o | output | 1 | Memory block read request |
| mem_addr_o | output | ADDR_W | Block address of the memory read |
| mem_ack_i | input | 1 | Memory read completes this cycle |
| mem_data_i | input | DATA_W | Block data, valid with mem_ack_i |

## Verification
The bench drives the fill port with one sequence of misses at a fixed memory latency. The spacing between misses is what varies. Misses to the next sequential address with a long enough gap must hit the buffer, which shows up as a one-cycle fill latency and the parked data. The same addresses sent before the prefetch has landed, including in the exact cycle its acknowledge arrives, must take the full memory latency. Misses to unrelated addresses tell a flush apart from a retained entry. An all-ones address separates wrapping from carry-out. A stray acknowledge and a reset in mid-stream show whether the buffer keeps or loses its block.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DEMAND = 2'd1,
    ST_PREF   = 2'd2
  } spb_state_e;
endpackage

// File: rtl/spb_entry.sv
module spb_entry #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] arm_tag_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [ADDR_W-1:0] probe_tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_q, pend_q;
  logic [ADDR_W-1:0] tag_q;
  logic [DATA_W-1:0] data_q;

  // arm beats flush: a hit reuses the entry for the next block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      tag_q   <= '0;
      data_q  <= '0;
    end else if (arm_i) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b1;
      tag_q   <= arm_tag_i;
    end else if (flush_i) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (load_i && pend_q) begin
      valid_q <= 1'b1;
      pend_q  <= 1'b0;
      data_q  <= load_data_i;
    end
  end

  // pending entries never hit (R7)
  assign hit_o  = valid_q && (tag_q == probe_tag_i);
  assign data_o = data_q;

  a_r7_valid_pend_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_q && pend_q));
  a_r4_load_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> pend_q);
  a_r6_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !arm_i) |=> !valid_q);
endmodule

// File: rtl/spb_ctrl.sv
module spb_ctrl
  import spb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_req_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              sb_hit_i,
  input  logic [DATA_W-1:0] sb_data_i,
  output logic              flush_o,
  output logic              arm_o,
  output logic [ADDR_W-1:0] arm_tag_o,
  output logic              load_o,
  output logic              fill_valid_o,
  output logic [DATA_W-1:0] fill_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              stall_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  spb_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] base_addr;
  logic              fill_q;
  logic [DATA_W-1:0] fill_data_q;
  logic              accept;
  logic              demand_done;

  assign accept      = miss_req_i && (state_q != ST_DEMAND) && !fill_q;
  assign demand_done = (state_q == ST_DEMAND) && mem_ack_i;
  assign base_addr   = accept ? miss_addr_i : addr_q;

  assign flush_o   = accept && !sb_hit_i;
  assign arm_o     = (accept && sb_hit_i) || demand_done;
  assign arm_tag_o = base_addr + ONE;
  // an ack landing with a demand accept is dropped (R7)
  assign load_o    = (state_q == ST_PREF) && mem_ack_i && !accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      fill_q      <= 1'b0;
      fill_data_q <= '0;
    end else if (accept) begin
      if (sb_hit_i) begin
        state_q     <= ST_PREF;
        addr_q      <= miss_addr_i + ONE;
        fill_q      <= 1'b1;
        fill_data_q <= sb_data_i;
      end else begin
        state_q <= ST_DEMAND;
        addr_q  <= miss_addr_i;
        fill_q  <= 1'b0;
      end
    end else if (demand_done) begin
      state_q     <= ST_PREF;
      addr_q      <= addr_q + ONE;
      fill_q      <= 1'b1;
      fill_data_q <= mem_data_i;
    end else begin
      fill_q <= 1'b0;
      if (state_q == ST_PREF && mem_ack_i) state_q <= ST_IDLE;
    end
  end

  assign fill_valid_o = fill_q;
  assign fill_data_o  = fill_data_q;
  assign mem_req_o    = (state_q != ST_IDLE);
  assign mem_addr_o   = addr_q;
  assign stall_o      = (state_q == ST_DEMAND);

  a_r2_demand_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !sb_hit_i) |=> (stall_o && mem_req_o && mem_addr_o == $past(miss_addr_i)));
  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  a_r3_fill_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |=> !fill_valid_o);
  a_r4_pf_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && mem_ack_i) |=> (fill_valid_o && !stall_o && mem_req_o
                                 && mem_addr_o == $past(mem_addr_o) + ONE));
  a_r5_hit_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && sb_hit_i) |=> (fill_valid_o && !stall_o
                               && mem_addr_o == $past(miss_addr_i) + ONE));
  a_r9_idle_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_req_o && !miss_req_i) |=> !fill_valid_o);
endmodule

// File: rtl/seq_pf_stream_buf.sv
module seq_pf_stream_buf #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_req_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  output logic              fill_valid_o,
  output logic [DATA_W-1:0] fill_data_o,
  output logic              stall_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_data_i
);
  logic              sb_hit, sb_flush, sb_arm, sb_load;
  logic [ADDR_W-1:0] sb_arm_tag;
  logic [DATA_W-1:0] sb_data;

  spb_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_entry (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (sb_flush),
    .arm_i       (sb_arm),
    .arm_tag_i   (sb_arm_tag),
    .load_i      (sb_load),
    .load_data_i (mem_data_i),
    .probe_tag_i (miss_addr_i),
    .hit_o       (sb_hit),
    .data_o      (sb_data)
  );

  spb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_req_i   (miss_req_i),
    .miss_addr_i  (miss_addr_i),
    .mem_ack_i    (mem_ack_i),
    .mem_data_i   (mem_data_i),
    .sb_hit_i     (sb_hit),
    .sb_data_i    (sb_data),
    .flush_o      (sb_flush),
    .arm_o        (sb_arm),
    .arm_tag_o    (sb_arm_tag),
    .load_o       (sb_load),
    .fill_valid_o (fill_valid_o),
    .fill_data_o  (fill_data_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .stall_o      (stall_o)
  );
endmodule

// File: tb/seq_pf_stream_buf_tb.sv
module seq_pf_stream_buf_tb;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam int LAT = 2;
  localparam int NV  = 12;
  // {addr[16:5], gap[4:1], expect_hit[0]}
  localparam logic [16:0] TBL [NV] = '{
    {12'h010, 4'd1, 1'b0},  // R1 cold miss
    {12'h011, 4'd4, 1'b1},  // R5
    {12'h012, 4'd3, 1'b1},  // R5 earliest hit
    {12'h013, 4'd2, 1'b0},  // R7 ack in accept cycle
    {12'h014, 4'd3, 1'b1},
    {12'h080, 4'd3, 1'b0},  // R6 flush
    {12'h015, 4'd4, 1'b0},  // R6 old block gone
    {12'h200, 4'd1, 1'b0},  // R7 pending, other addr
    {12'hFFF, 4'd5, 1'b0},  // R10
    {12'h000, 4'd3, 1'b1},  // R10 wrapped hit
    {12'h001, 4'd6, 1'b1},
    {12'h001, 4'd3, 1'b0}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          miss_req_i = 1'b0;
  logic [AW-1:0] miss_addr_i = '0;
  logic          fill_valid_o, stall_o, mem_req_o;
  logic [DW-1:0] fill_data_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_ack_i;
  logic [DW-1:0] mem_data_i;

  logic          resp_en = 1'b1;
  logic          man_ack = 1'b0;
  logic [DW-1:0] man_data = '0;
  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  seq_pf_stream_buf #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .miss_req_i(miss_req_i), .miss_addr_i(miss_addr_i),
    .fill_valid_o(fill_valid_o), .fill_data_o(fill_data_o), .stall_o(stall_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
    .mem_data_i(mem_data_i)
  );

  function automatic logic [DW-1:0] blk(input logic [AW-1:0] a);
    return {8'hC3, a, a ^ 12'h9A6};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model: LAT idle cycles, restarts when the address changes
  initial begin
    int cnt;
    logic [AW-1:0] last;
    cnt = 0; last = '0; mem_ack_i = 1'b0; mem_data_i = '0;
    forever begin
      @(negedge clk_i);
      if (!resp_en) begin
        mem_ack_i  = man_ack;
        mem_data_i = man_data;
        cnt = 0;
      end else begin
        if (!mem_req_o || mem_addr_o != last) cnt = 0;
        if (mem_req_o && cnt == LAT) begin
          mem_ack_i  = 1'b1;
          mem_data_i = blk(mem_addr_o);
          cnt = 0;
        end else begin
          mem_ack_i = 1'b0;
          if (mem_req_o) cnt++;
        end
        last = mem_addr_o;
      end
    end
  end

  // called at a negedge; returns at the negedge showing the fill
  task automatic run_miss(input logic [AW-1:0] a, input logic hit);
    int n;
    logic got;
    n = 0; got = 1'b0;
    miss_addr_i = a;
    miss_req_i  = 1'b1;
    while (!got && n < 40) begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
      if (fill_valid_o) got = 1'b1;
      else if (!hit) begin
        chk("R2 stall during demand", 32'(stall_o), 32'd1);
        chk("R8 demand request held", {19'd0, mem_req_o, mem_addr_o}, {19'd0, 1'b1, a});
      end
    end
    chk(hit ? "R5 hit latency" : "R3 miss latency", 32'(n), hit ? 32'd1 : 32'(LAT + 2));
    chk(hit ? "R5 parked data" : "R3 fill data", fill_data_o, blk(a));
    chk("R4 next block requested", {19'd0, mem_req_o, mem_addr_o}, {19'd0, 1'b1, a + 12'd1});
    chk("R3 stall released", 32'(stall_o), 32'd0);
    miss_req_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset outputs", {29'd0, fill_valid_o, mem_req_o, stall_o}, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      repeat (int'(TBL[i][4:1])) @(negedge clk_i);
      run_miss(TBL[i][16:5], TBL[i][0]);
    end

    // R9: stray ack while idle with block 0x002 parked
    repeat (6) @(negedge clk_i);
    @(posedge clk_i);
    resp_en = 1'b0; man_ack = 1'b1; man_data = 32'hDEAD_BEEF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R9 no fill on stray ack", {30'd0, fill_valid_o, mem_req_o}, 32'd0);
    end
    @(posedge clk_i); man_ack = 1'b0;
    @(posedge clk_i); resp_en = 1'b1;
    @(negedge clk_i);
    run_miss(12'h002, 1'b1);  // R9 buffer kept its block

    // R1: reset drops parked 0x003
    repeat (6) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset outputs", {29'd0, fill_valid_o, mem_req_o, stall_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    run_miss(12'h003, 1'b0);  // R1 buffer emptied by reset

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule